// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache when a lookup misses. It takes a 32-bit virtual address with 4 KB pages and walks a two-level table in memory. The walk makes two loads through a simple read port that allows one read at a time. The first load fetches the directory entry. Its address is the directory base frame with the top ten address bits appended as a word index. If that entry is valid, the second load fetches the table entry. Its address is the directory entry's frame with the middle ten address bits appended as a word index.

A good walk ends with a one-cycle response. The response carries the physical frame number and the write-enable, user, accessed and dirty bits, so the cache can install the translation and the access can be retried. A failed check on either entry ends the walk with a one-cycle fault pulse. The pulse carries a code that says which level failed, plus the virtual address that caused the fault, so software can handle the trap.

Each directory and each table holds 1024 words of 32 bits, one page each. Every entry has the same layout:

- bits 31:12: frame number
- bit 0: present; clear means the entry is invalid
- bit 1: writable
- bit 2: user access allowed
- bit 5: accessed
- bit 6: dirty

Top module: `tbl_walker`

## Requirements
- R1: After reset, `busy`, `memRdEn`, `rspValid` and `faultValid` are all low.
- R2: A request is taken only while `busy` is low. `busy` goes high on the edge that takes the request and stays high until the result pulse ends. While `busy` is high, `reqValid` and `reqVaddr` have no effect.
- R3: The first read is a one-cycle `memRdEn` pulse at address `{dirBase[31:12], va[31:22], 2'b00}`. `dirBase` is sampled only when the request is taken.
- R4: The second read is a one-cycle `memRdEn` pulse at address `{dirEntry[31:12], va[21:12], 2'b00}`.
- R5: A directory entry with bit 0 clear ends the walk. No second read is made, and a one-cycle `faultValid` pulse carries `faultCode` = 2'b01 and `faultVaddr` = the request address.
- R6: A table entry with bit 0 clear ends the walk with a one-cycle `faultValid` pulse that carries `faultCode` = 2'b10 and `faultVaddr` = the request address.
- R7: A table entry with bit 0 set gives a one-cycle `rspValid` pulse. The fields on that pulse are:
  - `rspFrame` = entry bits 31:12
  - `rspWritable` = bit 1
  - `rspUser` = bit 2
  - `rspAccessed` = bit 5
  - `rspDirty` = bit 6
- R8: Suppose the request is taken at edge E, the directory read data is captured Ld edges after its read pulse, and the table read data is captured Lp edges after its read pulse. Then a directory fault is shown after edge E+Ld+1, and a table fault or a response is shown after edge E+Ld+Lp+2.
- R9: `rspValid`, `faultValid` and `memRdEn` are never high together. Each request that is taken gives exactly one result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| dirBase | input | 32 | Physical address of the current directory (bits 31:12 used) |
| reqValid | input | 1 | Miss request |
| reqVaddr | input | 32 | Virtual address that missed |
| busy | output | 1 | A walk is in progress |
| memRdEn | output | 1 | One-cycle read request |
| memAddr | output | 32 | Read address |
| memRdValid | input | 1 | Read data valid, one cycle |
| memRdData | input | 32 | Read data |
| rspValid | output | 1 | Translation result, one cycle |
| rspFrame | output | 20 | Physical frame number |
| rspWritable | output | 1 | Page is writable |
| rspUser | output | 1 | User access allowed |
| rspAccessed | output | 1 | Accessed bit of the entry |
| rspDirty | output | 1 | Dirty bit of the entry |
| faultValid | output | 1 | Walk failed, one cycle |
| faultCode | output | 2 | 01 directory fault, 10 table fault |
| faultVaddr | output | 32 | Virtual address that faulted |

## Verification
Results fall on fixed edges counted from the accepting edge: Ld+1 edges for a directory fault, and Ld+Lp+2 edges for a table fault or a response. The bench memory sets Ld and Lp for each walk, and the driver stores the due cycle in each scoreboard item. The monitor samples on falling edges and compares the cycle number of each result pulse with that due value. The memory model also checks each read address on the falling edge after `memRdEn` is seen, and counts the reads, so a directory fault that still reads a table is caught.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    IDLE, READ_DIR, WAIT_DIR, READ_PTE, WAIT_PTE, DONE, FAULT
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic rdDir;
    logic rdPte;
    logic capDir;
    logic capPte;
    logic dirBad;
    logic pteBad;
  } walkStrobe_t;

  localparam logic [1:0] CODE_DIR = 2'b01;
  localparam logic [1:0] CODE_TBL = 2'b10;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_ACCESS  = 5;
  localparam int BIT_DIRTY   = 6;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  input  logic        entryPresent,
  output walkStrobe_t stb,
  output logic        busy,
  output logic        memRdEn,
  output logic        rspValid,
  output logic        faultValid
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    unique case (state)
      IDLE: begin
        if (reqValid) begin
          stb.accept = 1'b1;
          nextState  = READ_DIR;
        end
      end
      READ_DIR: begin
        stb.rdDir = 1'b1;
        nextState = WAIT_DIR;
      end
      WAIT_DIR: begin
        if (memRdValid) begin
          stb.capDir = 1'b1;
          if (!entryPresent) begin
            stb.dirBad = 1'b1;
            nextState  = FAULT;
          end else begin
            nextState = READ_PTE;
          end
        end
      end
      READ_PTE: begin
        stb.rdPte = 1'b1;
        nextState = WAIT_PTE;
      end
      WAIT_PTE: begin
        if (memRdValid) begin
          stb.capPte = 1'b1;
          if (!entryPresent) begin
            stb.pteBad = 1'b1;
            nextState  = FAULT;
          end else begin
            nextState = DONE;
          end
        end
      end
      DONE:    nextState = IDLE;
      FAULT:   nextState = IDLE;
      default: nextState = IDLE;
    endcase
  end

  assign busy       = (state != IDLE);
  assign memRdEn    = stb.rdDir | stb.rdPte;
  assign rspValid   = (state == DONE);
  assign faultValid = (state == FAULT);
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int OFF_W = IDX_W + 2,
  localparam int ADDR_W = 2 * IDX_W + OFF_W,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        stb,
  input  logic [ADDR_W-1:0]  reqVaddr,
  input  logic [ADDR_W-1:0]  dirBase,
  input  logic [ADDR_W-1:0]  memRdData,
  output logic               entryPresent,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [FRAME_W-1:0] rspFrame,
  output logic               rspWritable,
  output logic               rspUser,
  output logic               rspAccessed,
  output logic               rspDirty,
  output logic [1:0]         faultCode,
  output logic [ADDR_W-1:0]  faultVaddr
);
  logic [ADDR_W-1:0]  vaReg;
  logic [FRAME_W-1:0] baseFrame;
  logic [FRAME_W-1:0] tblFrame;
  logic [ADDR_W-1:0]  pteReg;
  logic [1:0]         codeReg;
  logic [IDX_W-1:0]   dirIdx, tblIdx;

  assign dirIdx = vaReg[ADDR_W-1 -: IDX_W];
  assign tblIdx = vaReg[OFF_W +: IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      baseFrame <= '0;
      tblFrame  <= '0;
      pteReg    <= '0;
      codeReg   <= '0;
    end else begin
      if (stb.accept) begin
        vaReg     <= reqVaddr;
        baseFrame <= dirBase[ADDR_W-1:OFF_W];
      end
      if (stb.capDir) tblFrame <= memRdData[ADDR_W-1:OFF_W];
      if (stb.capPte) pteReg   <= memRdData;
      if (stb.dirBad) codeReg  <= CODE_DIR;
      if (stb.pteBad) codeReg  <= CODE_TBL;
    end
  end

  assign entryPresent = memRdData[BIT_PRESENT];
  assign memAddr = stb.rdPte ? {tblFrame, tblIdx, 2'b00}
                             : {baseFrame, dirIdx, 2'b00};

  assign rspFrame    = pteReg[ADDR_W-1:OFF_W];
  assign rspWritable = pteReg[BIT_WRITE];
  assign rspUser     = pteReg[BIT_USER];
  assign rspAccessed = pteReg[BIT_ACCESS];
  assign rspDirty    = pteReg[BIT_DIRTY];
  assign faultCode   = codeReg;
  assign faultVaddr  = vaReg;
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import walk_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int ADDR_W = 3 * IDX_W + 2,
  localparam int FRAME_W = 2 * IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  dirBase,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqVaddr,
  output logic               busy,
  output logic               memRdEn,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memRdValid,
  input  logic [ADDR_W-1:0]  memRdData,
  output logic               rspValid,
  output logic [FRAME_W-1:0] rspFrame,
  output logic               rspWritable,
  output logic               rspUser,
  output logic               rspAccessed,
  output logic               rspDirty,
  output logic               faultValid,
  output logic [1:0]         faultCode,
  output logic [ADDR_W-1:0]  faultVaddr
);
  walkStrobe_t stb;
  logic        entryPresent;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRdValid(memRdValid),
    .entryPresent(entryPresent), .stb(stb), .busy(busy), .memRdEn(memRdEn),
    .rspValid(rspValid), .faultValid(faultValid)
  );

  walk_dpath #(.IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqVaddr(reqVaddr), .dirBase(dirBase),
    .memRdData(memRdData), .entryPresent(entryPresent), .memAddr(memAddr),
    .rspFrame(rspFrame), .rspWritable(rspWritable), .rspUser(rspUser),
    .rspAccessed(rspAccessed), .rspDirty(rspDirty), .faultCode(faultCode),
    .faultVaddr(faultVaddr)
  );
endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int IDX_W = 10,
  localparam int ADDR_W = 3 * IDX_W + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              memRdEn,
  input logic              rspValid,
  input logic              faultValid,
  input logic [1:0]        faultCode,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic [ADDR_W-1:0] faultVaddr
);
  assert_take_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  assert_result_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || faultValid) |-> busy);

  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultCode == 2'b01 || faultCode == 2'b10));

  assert_fault_va_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> (faultVaddr == $past(reqVaddr)));

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && !busy));

  assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> (!faultValid && !busy));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspValid, faultValid, memRdEn}));
endmodule

bind tbl_walker walk_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .memRdEn(memRdEn),
  .rspValid(rspValid), .faultValid(faultValid), .faultCode(faultCode),
  .reqVaddr(reqVaddr), .faultVaddr(faultVaddr)
);

// File: tb/sim_tbl_walker.sv
`timescale 1ns/1ps
module sim_tbl_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dirBase = 32'h0010_0000;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        busy, memRdEn, memRdValid = 1'b0;
  logic [31:0] memAddr, memRdData = '0;
  logic        rspValid, rspWritable, rspUser, rspAccessed, rspDirty, faultValid;
  logic [19:0] rspFrame;
  logic [1:0]  faultCode;
  logic [31:0] faultVaddr;

  always #2.5 clk = ~clk;

  tbl_walker u0 (
    .clk(clk), .rstN(rstN), .dirBase(dirBase), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .busy(busy), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .rspValid(rspValid),
    .rspFrame(rspFrame), .rspWritable(rspWritable), .rspUser(rspUser),
    .rspAccessed(rspAccessed), .rspDirty(rspDirty), .faultValid(faultValid),
    .faultCode(faultCode), .faultVaddr(faultVaddr)
  );

  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;
  bit finished = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // sparse memory
  logic [31:0] mem [int unsigned];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  int curLd = 1, curLp = 1, readCnt = 0, countdown = 0;
  logic [31:0] expDirAddr, expPteAddr, pendAddr;

  always @(negedge clk) begin
    if (memRdValid) memRdValid = 1'b0;
    if (countdown > 0) begin
      countdown--;
      if (countdown == 0) begin
        memRdValid = 1'b1;
        memRdData  = rd(pendAddr);
      end
    end
    if (rstN && memRdEn) begin
      if (readCnt == 0)
        check(memAddr == expDirAddr, "R3", "directory read address", memAddr, expDirAddr);
      else
        check(memAddr == expPteAddr, "R4", "table read address", memAddr, expPteAddr);
      pendAddr  = memAddr;
      countdown = (readCnt == 0) ? curLd : curLp;
      readCnt++;
    end
  end

  typedef struct {
    bit          isFault;
    logic [1:0]  code;
    logic [19:0] frame;
    logic [3:0]  flags;
    logic [31:0] va;
    int          due;
    int          nReads;
  } item_t;
  item_t q[$];

  // monitor
  always @(negedge clk) begin
    if (rstN && (rspValid || faultValid)) begin
      check(!(rspValid && faultValid), "R9", "both result pulses", {rspValid, faultValid}, 2'b00);
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected result pulse", {rspValid, faultValid}, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(cycleCnt == it.due, "R8", "result cycle", cycleCnt, it.due);
        check(readCnt == it.nReads, it.isFault && it.code == 2'b01 ? "R5" : "R4",
              "read count", readCnt, it.nReads);
        if (it.isFault) begin
          check(faultValid, it.code == 2'b01 ? "R5" : "R6", "fault pulse", faultValid, 1);
          check(faultCode == it.code, it.code == 2'b01 ? "R5" : "R6", "fault code", faultCode, it.code);
          check(faultVaddr == it.va, it.code == 2'b01 ? "R5" : "R6", "fault address", faultVaddr, it.va);
        end else begin
          check(rspValid, "R7", "response pulse", rspValid, 1);
          check(rspFrame == it.frame, "R7", "frame", rspFrame, it.frame);
          check({rspDirty, rspAccessed, rspUser, rspWritable} == it.flags, "R7", "flags",
                {rspDirty, rspAccessed, rspUser, rspWritable}, it.flags);
        end
      end
    end
  end

  function automatic logic [31:0] va(input int d, input int t, input int o);
    return {d[9:0], t[9:0], o[11:0]};
  endfunction

  task automatic doWalk(input logic [31:0] v, input int ld, input int lp,
                        input bit holdOther, input bit moveBase);
    item_t it;
    logic [31:0] pde, pte;
    int e;
    @(negedge clk);
    while (busy) @(negedge clk);
    expDirAddr = {dirBase[31:12], v[31:22], 2'b00};
    pde = rd(expDirAddr);
    expPteAddr = {pde[31:12], v[21:12], 2'b00};
    pte = rd(expPteAddr);
    curLd = ld; curLp = lp; readCnt = 0;
    it.va = v;
    it.frame = pte[31:12];
    it.flags = {pte[6], pte[5], pte[2], pte[1]};
    if (!pde[0]) begin
      it.isFault = 1; it.code = 2'b01; it.nReads = 1;
    end else if (!pte[0]) begin
      it.isFault = 1; it.code = 2'b10; it.nReads = 2;
    end else begin
      it.isFault = 0; it.code = 2'b00; it.nReads = 2;
    end
    reqVaddr = v;
    reqValid = 1'b1;
    @(posedge clk);
    #1;
    e = cycleCnt;
    it.due = (it.isFault && it.code == 2'b01) ? e + ld + 1 : e + ld + lp + 2;
    q.push_back(it);
    @(negedge clk);
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    if (moveBase) dirBase = 32'h0090_0000;
    if (holdOther) begin
      reqVaddr = va(3, 0, 0);
      @(negedge clk);
      @(negedge clk);
    end
    reqValid = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R2", "busy after result", busy, 0);
    dirBase = 32'h0010_0000;
  endtask

  initial begin
    mem[32'h0010_0000 + 4 * 1]     = 32'h0020_0001;
    mem[32'h0010_0000 + 4 * 3]     = 32'h0030_0000;
    mem[32'h0010_0000 + 4 * 10'h3FF] = 32'h0040_0001;
    mem[32'h0020_0000 + 4 * 5]     = 32'hABCD_E023;
    mem[32'h0020_0000 + 4 * 6]     = 32'h1234_5047;
    mem[32'h0020_0000 + 4 * 7]     = 32'h5555_5062;
    mem[32'h0040_0000 + 4 * 10'h3FF] = 32'hFFFF_F065;
    mem[32'h0040_0000]             = 32'h0000_1001;

    repeat (3) @(negedge clk);
    check({busy, memRdEn, rspValid, faultValid} == 4'b0, "R1", "outputs in reset",
          {busy, memRdEn, rspValid, faultValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, memRdEn, rspValid, faultValid} == 4'b0, "R1", "outputs after reset",
          {busy, memRdEn, rspValid, faultValid}, 0);

    doWalk(va(1, 5, 12'h123), 1, 1, 0, 0);        // R7 plain hit
    doWalk(va(1, 6, 12'hFFF), 3, 2, 0, 0);        // R7 other flags, R8 latency
    doWalk(va(3, 0, 0), 2, 1, 0, 0);              // R5 directory fault
    doWalk(va(1, 7, 12'h010), 1, 3, 0, 0);        // R6 table fault
    doWalk(va(10'h3FF, 10'h3FF, 12'hABC), 1, 1, 0, 0); // top index
    doWalk(va(10'h3FF, 0, 0), 2, 1, 0, 0);        // bottom table index
    doWalk(va(1, 5, 12'h777), 1, 2, 1, 0);        // R2 request ignored while busy
    doWalk(va(1, 6, 0), 2, 2, 0, 1);              // R3 base sampled at accept
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9", "pending results", q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycleCnt == 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired: actual %0d expected 0", cycleCnt);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule